// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one burst request into the column address of every beat of an SDRAM read or write burst. A request carries a starting column, a three-bit length code and an ordering bit that picks sequential or interleaved ordering. A one-cycle start pulse begins the burst. From the next cycle on, the block presents one column per clock with a valid flag. It marks the final beat of a fixed-length burst.

For fixed lengths the column bits above the in-block offset stay fixed. The offset either counts upward and wraps inside the aligned block, or it is the start offset XORed with the beat index. The full-page length instead steps through the whole row, wrapping modulo the row size. It keeps going until a stop pulse ends it. The column width is a parameter: 11 bits for x4, 10 for x8 and 9 for x16 parts. A new start pulse always aborts a burst in flight.

Top module: `sdram_burst_colseq`

## Requirements
- R1: After reset, `beat_valid_o`, `beat_last_o` and `cfg_err_o` are 0.
- R2: A start pulse sampled at a clock edge presents `start_col_i` on `col_o` with `beat_valid_o`=1 right after that edge. Each following beat comes one clock later.
- R3: The length code selects the beat count: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8, 3'b111=full page. A fixed burst gives exactly that many valid beats. `beat_last_o` is high only on the final beat, and valid falls on the cycle after it.
- R4: With `ilv_i`=0 (sequential), the low log2(BL) column bits count up from the start and wrap inside the aligned block. The upper bits stay equal to those of the start column.
- R5: With `ilv_i`=1 (interleaved), beat k has low bits equal to the start's low bits XOR k. The upper bits stay fixed.
- R6: With length 1, exactly one beat is issued at the start column, whatever `ilv_i` is.
- R7: A full-page burst presents start+k modulo 2^COL_W on beat k and never raises `beat_last_o`.
- R8: A `stop_i` pulse without a start clears `beat_valid_o` after the next clock edge.
- R9: Full page with `ilv_i`=1 runs in sequential order and sets `cfg_err_o`.
- R10: A start with a reserved code (3'b100, 3'b101, 3'b110) sets `cfg_err_o`. It issues no beat and ends any burst in progress.
- R11: A start during an active burst abandons it; the next cycle shows beat 0 of the new burst.
- R12: `cfg_err_o` is updated only at a start and is cleared by a start with a legal combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a burst with the request fields below |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 sequential, 1 interleaved ordering |
| start_col_i | input | COL_W | Starting column |
| stop_i | input | 1 | Ends the active burst |
| col_o | output | COL_W | Column for the current beat |
| beat_valid_o | output | 1 | `col_o` holds a live beat |
| beat_last_o | output | 1 | Current beat is the final beat of a fixed burst |
| cfg_err_o | output | 1 | Last start used a reserved code or full page with interleave |

## Verification
The hardest case to reach from the ports is the modulo-row wrap of a full-page burst. It only shows up after a run that crosses the top column of the row. The bench starts full-page bursts a few columns below the row end and runs more than a full row of beats before stopping, so both the wrap and the long stable stream are observed. A restart is injected in the middle of a wrapping eight-beat burst, and a reserved code is issued during a full-page run. These show that abort and rejection take effect at the very next edge.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;
endpackage

// File: rtl/colseq_mode_dec.sv
module colseq_mode_dec
  import colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [2:0]       len_code,
  input  logic             ilv_req,
  output logic [COL_W-1:0] offs_mask,
  output logic             full_page,
  output logic             ilv_eff,
  output logic             bad_code,
  output logic             bad_combo
);
  always_comb begin
    offs_mask = '0;
    full_page = 1'b0;
    bad_code  = 1'b0;
    case (len_code)
      LEN_ONE:   offs_mask = '0;
      LEN_TWO:   offs_mask = COL_W'(1);
      LEN_FOUR:  offs_mask = COL_W'(3);
      LEN_EIGHT: offs_mask = COL_W'(7);
      LEN_PAGE: begin
        offs_mask = '1;
        full_page = 1'b1;
      end
      default:   bad_code = 1'b1;
    endcase
    bad_combo = full_page && ilv_req;
    ilv_eff   = ilv_req && !full_page;
  end
endmodule

// File: rtl/colseq_addr_map.sv
module colseq_addr_map #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] offs_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + beat;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = offs_mask[b] ? (ilv ? (base[b] ^ beat[b]) : sum[b]) : base[b];
  end
endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             beat_last_o,
  output logic             cfg_err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full, dec_ilv, dec_bad_code, dec_bad_combo;

  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             ilv_q, full_q;
  logic [COL_W-1:0] beat_nx, col_nx;

  colseq_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code (len_code_i),
    .ilv_req  (ilv_i),
    .offs_mask(dec_mask),
    .full_page(dec_full),
    .ilv_eff  (dec_ilv),
    .bad_code (dec_bad_code),
    .bad_combo(dec_bad_combo)
  );

  assign beat_nx = beat_q + COL_W'(1);

  colseq_addr_map #(.COL_W(COL_W)) u_map (
    .base     (base_q),
    .beat     (beat_nx),
    .offs_mask(mask_q),
    .ilv      (ilv_q),
    .col      (col_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q       <= '0;
      beat_q       <= '0;
      mask_q       <= '0;
      ilv_q        <= 1'b0;
      full_q       <= 1'b0;
      col_o        <= '0;
      beat_valid_o <= 1'b0;
      beat_last_o  <= 1'b0;
      cfg_err_o    <= 1'b0;
    end else if (start_i) begin
      cfg_err_o <= dec_bad_code || dec_bad_combo;
      if (dec_bad_code) begin
        beat_valid_o <= 1'b0;
        beat_last_o  <= 1'b0;
        full_q       <= 1'b0;
      end else begin
        base_q       <= start_col_i;
        beat_q       <= '0;
        mask_q       <= dec_mask;
        ilv_q        <= dec_ilv;
        full_q       <= dec_full;
        col_o        <= start_col_i;
        beat_valid_o <= 1'b1;
        beat_last_o  <= !dec_full && (dec_mask == '0);
      end
    end else if (stop_i) begin
      beat_valid_o <= 1'b0;
      beat_last_o  <= 1'b0;
    end else if (beat_valid_o) begin
      if (beat_last_o) begin
        beat_valid_o <= 1'b0;
        beat_last_o  <= 1'b0;
      end else begin
        beat_q      <= beat_nx;
        col_o       <= col_nx;
        beat_last_o <= !full_q && (beat_nx == mask_q);
      end
    end
  end

  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    beat_last_o |-> beat_valid_o);

  // R3
  ends_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && beat_last_o && !start_i) |=> !beat_valid_o);

  // R2
  start_loads_col_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && (len_code_i[2] == 1'b0 || len_code_i == 3'b111))
      |=> (beat_valid_o && col_o == $past(start_col_i)));

  // R4
  block_bits_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && !beat_last_o && !start_i && !stop_i)
      |=> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

  // R7
  page_never_last_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && full_q) |-> !beat_last_o);

  // R9
  page_steps_up_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && full_q && !start_i && !stop_i)
      |=> (beat_valid_o && col_o == $past(col_o) + COL_W'(1)));

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i) |=> !beat_valid_o);

  // R10
  reserved_rejects_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_code_i[2] && len_code_i != 3'b111) |=> (cfg_err_o && !beat_valid_o));
endmodule

// File: tb/test_sdram_burst_colseq.sv
module test_sdram_burst_colseq;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [2:0]    len_code_i = 3'b000;
  logic          ilv_i = 1'b0;
  logic [CW-1:0] start_col_i = '0;
  logic          stop_i = 1'b0;
  logic [CW-1:0] col_o;
  logic          beat_valid_o, beat_last_o, cfg_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_burst_colseq #(.COL_W(CW)) i_sdram_burst_colseq (
    .clk(clk), .rst(rst), .start_i(start_i), .len_code_i(len_code_i),
    .ilv_i(ilv_i), .start_col_i(start_col_i), .stop_i(stop_i),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .beat_last_o(beat_last_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int k, input int m, input bit ilv);
    int low;
    low = ilv ? ((s ^ k) & m) : ((s + k) & m);
    return (s & ~m & ((1 << CW) - 1)) | low;
  endfunction

  task automatic issue(input logic [2:0] code, input bit ilv, input int s);
    @(negedge clk);
    start_i = 1'b1; len_code_i = code; ilv_i = ilv; start_col_i = CW'(s);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // R2 R3 R4 R5 R6: one fixed burst checked beat by beat
  task automatic fixed_burst(input logic [2:0] code, input bit ilv, input int s);
    int n, m;
    string tg;
    n = 1 << code;
    m = n - 1;
    tg = (code == 3'b000) ? "R6" : (ilv ? "R5" : "R4");
    issue(code, ilv, s);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      chk({tg, " col"}, int'(col_o), (code == 3'b000) ? s : exp_col(s, k, m, ilv));
      chk("R2 valid", int'(beat_valid_o), 1);
      chk("R3 last", int'(beat_last_o), (k == n - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk("R3 valid after last", int'(beat_valid_o), 0);
    chk("R12 err clear", int'(cfg_err_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid", int'(beat_valid_o), 0);
    chk("R1 last", int'(beat_last_o), 0);
    chk("R1 err", int'(cfg_err_o), 0);

    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++) begin
        for (int s = 0; s < 24; s++) fixed_burst(3'(c), t[0], s);
        for (int s = (1 << CW) - 9; s < (1 << CW); s++) fixed_burst(3'(c), t[0], s);
      end

    // R7: full page across the row end, longer than one row, then stop
    issue(3'b111, 1'b0, (1 << CW) - 3);
    for (int k = 0; k < (1 << CW) + 20; k++) begin
      if (k > 0) @(negedge clk);
      if (k < 8 || k > (1 << CW)) begin
        chk("R7 col", int'(col_o), ((1 << CW) - 3 + k) % (1 << CW));
        chk("R7 last", int'(beat_last_o), 0);
        chk("R7 valid", int'(beat_valid_o), 1);
      end
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R8 valid after stop", int'(beat_valid_o), 0);
    chk("R8 last after stop", int'(beat_last_o), 0);

    // R9: interleave requested with full page falls back to sequential
    issue(3'b111, 1'b1, 5);
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      chk("R9 col", int'(col_o), 5 + k);
      chk("R9 err", int'(cfg_err_o), 1);
    end

    // R10: reserved code aborts the running page burst
    for (int c = 4; c < 7; c++) begin
      issue(3'(c), 1'b0, 40);
      chk("R10 valid", int'(beat_valid_o), 0);
      chk("R10 err", int'(cfg_err_o), 1);
      repeat (2) @(negedge clk);
      chk("R10 still idle", int'(beat_valid_o), 0);
      issue(3'b111, 1'b0, 100);
      chk("R12 err cleared", int'(cfg_err_o), 0);
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R8 stop", int'(beat_valid_o), 0);

    // R11: restart in the middle of a wrapping 8-beat burst
    issue(3'b011, 1'b0, 6);
    chk("R11 first col", int'(col_o), 6);
    @(negedge clk);
    chk("R11 second col", int'(col_o), 7);
    @(negedge clk);
    chk("R11 wrap col", int'(col_o), 0);
    fixed_burst(3'b010, 1'b1, 18);
    chk("R11 idle after new burst", int'(beat_valid_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule